// File: doc/BRIEF.md
# Multichannel Serial Output Framer

The framer takes complete blocks of four complex samples from an upstream block store and shifts them out as bit-serial words on four data lines. It also drives a one-bit-period frame strobe. Every state change happens on a cycle in which an external bit-clock enable is high, so a separate divider sets the line rate. Upstream raises a ready flag when a whole block is waiting. The framer takes the block with a single pop pulse in the cycle the new frame starts.

Each channel has an in-phase part and a quadrature part, both 24 bits. They are sent as words of a selectable length, with the in-phase word first and the most significant bit first. A real-only mode sends just the quadrature word. Three packing modes put the four channels on one, two or four logical streams. A per-pin selector then routes any logical stream to each physical pin. A programmable minimum frame length pads a frame with low bit periods, which leaves room on a shared serial bus.

Configuration is captured when a frame starts and stays fixed until that frame ends, so software may change it at any time.

Top module: `sout_framer`

## Requirements
- R1: In complex mode a channel's in-phase word and then its quadrature word go out on one stream, each most significant bit first.
- R2: With `cfg_real_only` high, only the quadrature word of each channel is sent, and a channel takes one word slot.
- R3: `cfg_wsel` picks the word length: 0→12, 1→16, 2→20, 3→24, 4→28, 5 and above→32 bits.
- R4: For words shorter than 24 bits, the top bits of the sample are sent and the rest are dropped. For words longer than 24 bits, the 24 sample bits are followed by zeros.
- R5: `cfg_pack` 0 places channels 0,1,2,3 in that order on stream 0. Code 1 places channels 0,1 on stream 0 and channels 2,3 on stream 1. Codes 2 and 3 place channel s alone on stream s. Unused streams stay low.
- R6: A frame starts on a bit-enable cycle only when no frame is running, or the current frame is on its last bit, and `blk_ready` is high. `blk_pop` is high in exactly that cycle, so frames can run back to back.
- R7: A frame lasts max(words per stream, `cfg_flen`+1) words of the selected length. Slots with no data are sent low.
- R8: Pin p carries the logical stream numbered by `cfg_pin_sel[2p+1:2p]`.
- R9: `sfs` is high for exactly the first bit period of every frame.
- R10: The outputs change only after a cycle with `bit_en` high. All data lines are low while no frame is running.
- R11: Configuration is sampled at frame start. Changes during a frame affect only later frames.
- R12: After reset, `sfs` and `sout` are low and `blk_pop` stays low until a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one bit period per high cycle |
| blk_ready | input | 1 | A full four-channel block is available |
| blk_i | input | 96 | In-phase samples, channel c at bits [24c+23:24c] |
| blk_q | input | 96 | Quadrature samples, channel c at bits [24c+23:24c] |
| cfg_wsel | input | 3 | Word length code |
| cfg_real_only | input | 1 | Send quadrature words only |
| cfg_pack | input | 2 | Channel-to-stream packing code |
| cfg_flen | input | 6 | Minimum frame length in words, minus one |
| cfg_pin_sel | input | 8 | Stream number for each of the four pins, two bits per pin |
| blk_pop | output | 1 | Consume the presented block |
| sfs | output | 1 | Frame strobe |
| sout | output | 4 | Serial data pins |

## Verification
A wrong word or bit counter shows up at once: `sfs` or the next `blk_pop` lands on the wrong bit period, and the error surfaces within one frame. A wrong channel or part selection gives wrong data on the line in the first bit period of the affected word. A configuration that leaks into a running frame changes the line contents as soon as it is applied. The reference model lists every expected bit per stream and compares the pins, the strobe and the pop on every cycle, so any such error is reported within one bit period.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int NCH   = 4;
  localparam int MAX_W = 32;

  typedef struct packed {
    logic [2:0] wsel;
    logic       real_only;
    logic [1:0] pack;
    logic [5:0] flen;
    logic [7:0] pin_sel;
  } cfg_t;

  function automatic logic [5:0] word_bits(input logic [2:0] wsel);
    case (wsel)
      3'd0:    return 6'd12;
      3'd1:    return 6'd16;
      3'd2:    return 6'd20;
      3'd3:    return 6'd24;
      3'd4:    return 6'd28;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [2:0] chans_per_stream(input logic [1:0] pack);
    case (pack)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] words_per_stream(input logic [1:0] pack,
                                                  input logic real_only);
    logic [3:0] c;
    c = {1'b0, chans_per_stream(pack)};
    return real_only ? c : (c << 1);
  endfunction

  function automatic logic [6:0] frame_words(input logic [1:0] pack,
                                             input logic real_only,
                                             input logic [5:0] flen);
    logic [6:0] wps, req;
    wps = {3'b000, words_per_stream(pack, real_only)};
    req = {1'b0, flen} + 7'd1;
    return (wps > req) ? wps : req;
  endfunction

endpackage

// File: rtl/sfr_seq.sv
module sfr_seq
  import sfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       blk_ready,
  input  cfg_t       cfg_in,
  output cfg_t       cfg_q,
  output logic       busy,
  output logic [5:0] word_idx,
  output logic [4:0] bit_idx,
  output logic       blk_pop,
  output logic       first_bit
);

  logic last_bit, word_end, frame_done;

  assign word_end   = ({1'b0, bit_idx} == word_bits(cfg_q.wsel) - 6'd1);
  assign last_bit   = busy && word_end &&
                      ({1'b0, word_idx} ==
                       frame_words(cfg_q.pack, cfg_q.real_only, cfg_q.flen) - 7'd1);
  assign frame_done = !busy || last_bit;
  assign blk_pop    = bit_en && frame_done && blk_ready;
  assign first_bit  = busy && (word_idx == '0) && (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      word_idx <= '0;
      bit_idx  <= '0;
      cfg_q    <= '0;
    end else if (bit_en) begin
      if (blk_pop) begin
        busy     <= 1'b1;
        word_idx <= '0;
        bit_idx  <= '0;
        cfg_q    <= cfg_in;
      end else if (last_bit) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (word_end) begin
          bit_idx  <= '0;
          word_idx <= word_idx + 6'd1;
        end else begin
          bit_idx <= bit_idx + 5'd1;
        end
      end
    end
  end

  // R7: word counter never runs past the frame length captured at start
  p_word_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, word_idx} <
              frame_words(cfg_q.pack, cfg_q.real_only, cfg_q.flen)));

endmodule

// File: rtl/sfr_lane.sv
module sfr_lane
  import sfr_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int LANE  = 0
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy,
  input  logic [5:0]             word_idx,
  input  logic [4:0]             bit_idx,
  input  logic [1:0]             pack,
  input  logic                   real_only,
  input  logic [NCH*SMP_W-1:0]   hold_i,
  input  logic [NCH*SMP_W-1:0]   hold_q,
  output logic                   bit_o
);

  localparam int PAD_W = MAX_W - SMP_W;
  localparam logic [4:0] TOP = 5'(MAX_W - 1);

  always_comb begin
    int               n, wps, chn;
    logic [1:0]       ch;
    logic             use_q;
    logic [SMP_W-1:0] smp;
    logic [MAX_W-1:0] fld;
    n     = int'(chans_per_stream(pack));
    wps   = int'(words_per_stream(pack, real_only));
    use_q = real_only | word_idx[0];
    chn   = LANE * n + (real_only ? int'(word_idx) : int'(word_idx[5:1]));
    ch    = 2'(chn);
    smp   = use_q ? hold_q[ch*SMP_W +: SMP_W] : hold_i[ch*SMP_W +: SMP_W];
    fld   = {smp, {PAD_W{1'b0}}};
    bit_o = 1'b0;
    if (busy && (int'(word_idx) < wps) && (LANE * n < NCH))
      bit_o = fld[TOP - bit_idx];
  end

  // R4: bit slots past the sample width carry zero
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx >= 5'(SMP_W)) |-> !bit_o);

endmodule

// File: rtl/sfr_pinmux.sv
module sfr_pinmux
  import sfr_pkg::*;
(
  input  logic [NCH-1:0]   stream,
  input  logic [2*NCH-1:0] pin_sel,
  output logic [NCH-1:0]   pins
);

  for (genvar p = 0; p < NCH; p++) begin : g_pin
    assign pins[p] = stream[pin_sel[2*p +: 2]];
  end

endmodule

// File: rtl/sout_framer.sv
module sout_framer
  import sfr_pkg::*;
#(
  parameter int SMP_W = 24
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  blk_ready,
  input  logic [4*SMP_W-1:0]    blk_i,
  input  logic [4*SMP_W-1:0]    blk_q,
  input  logic [2:0]            cfg_wsel,
  input  logic                  cfg_real_only,
  input  logic [1:0]            cfg_pack,
  input  logic [5:0]            cfg_flen,
  input  logic [7:0]            cfg_pin_sel,
  output logic                  blk_pop,
  output logic                  sfs,
  output logic [3:0]            sout
);

  cfg_t             cfg_in, cfg_q;
  logic             busy;
  logic [5:0]       word_idx;
  logic [4:0]       bit_idx;
  logic [NCH-1:0]   stream;
  logic [NCH*SMP_W-1:0] hold_i, hold_q;

  assign cfg_in = '{wsel: cfg_wsel, real_only: cfg_real_only, pack: cfg_pack,
                    flen: cfg_flen, pin_sel: cfg_pin_sel};

  sfr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .blk_ready(blk_ready),
    .cfg_in(cfg_in), .cfg_q(cfg_q), .busy(busy), .word_idx(word_idx),
    .bit_idx(bit_idx), .blk_pop(blk_pop), .first_bit(sfs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_i <= '0;
      hold_q <= '0;
    end else if (blk_pop) begin
      hold_i <= blk_i;
      hold_q <= blk_q;
    end
  end

  for (genvar s = 0; s < NCH; s++) begin : g_lane
    sfr_lane #(.SMP_W(SMP_W), .LANE(s)) u_lane (
      .clk(clk), .rst_n(rst_n), .busy(busy), .word_idx(word_idx),
      .bit_idx(bit_idx), .pack(cfg_q.pack), .real_only(cfg_q.real_only),
      .hold_i(hold_i), .hold_q(hold_q), .bit_o(stream[s])
    );
  end

  sfr_pinmux u_mux (.stream(stream), .pin_sel(cfg_q.pin_sel), .pins(sout));

  // R9: strobe lasts a single bit period
  p_sfs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sfs && bit_en) |=> !sfs);

  // R10: nothing moves without a bit enable
  p_hold_no_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(sout) && $stable(sfs)));

  // R10: lines idle low between frames
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sout == '0));

  // R6: a pop always opens a frame on the next bit period
  p_pop_starts_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_pop |=> sfs);

endmodule

// File: tb/sout_framer_tb_top.sv
module sout_framer_tb_top;

  localparam int SW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            bit_en = 1'b0, blk_ready = 1'b0;
  logic [4*SW-1:0] di = '0, dq = '0;
  logic [2:0]      wsel = 3'd3;
  logic            real_only = 1'b0;
  logic [1:0]      pack = 2'd2;
  logic [5:0]      flen = 6'd0;
  logic [7:0]      psel = 8'b11_10_01_00;
  logic            blk_pop, sfs;
  logic [3:0]      sout;

  sout_framer #(.SMP_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .blk_ready(blk_ready),
    .blk_i(di), .blk_q(dq), .cfg_wsel(wsel), .cfg_real_only(real_only),
    .cfg_pack(pack), .cfg_flen(flen), .cfg_pin_sel(psel),
    .blk_pop(blk_pop), .sfs(sfs), .sout(sout)
  );

  int    n_tests = 0, n_fail = 0;
  string tag = "R12";
  int    en_mode = 0, rdy_mode = 0;
  bit    churn = 0;

  // behavioural model: per-stream bit lists built at frame start
  int       m_pos = 0, m_total = 0;
  int       m_sq[4][$];
  logic [7:0] m_sel = '0;

  function automatic int wlen(input logic [2:0] s);
    case (s)
      3'd0: return 12; 3'd1: return 16; 3'd2: return 20;
      3'd3: return 24; 3'd4: return 28; default: return 32;
    endcase
  endfunction

  task automatic build_model();
    int w, n, wps, fw;
    logic [SW-1:0] smp;
    w   = wlen(wsel);
    n   = (pack == 2'd0) ? 4 : (pack == 2'd1) ? 2 : 1;
    wps = n * (real_only ? 1 : 2);
    fw  = (wps > int'(flen) + 1) ? wps : int'(flen) + 1;
    m_total = fw * w;
    m_sel   = psel;
    for (int s = 0; s < 4; s++) begin
      m_sq[s].delete();
      if (s * n < 4)
        for (int k = 0; k < n; k++)
          for (int part = (real_only ? 1 : 0); part < 2; part++) begin
            smp = part ? dq[(s*n+k)*SW +: SW] : di[(s*n+k)*SW +: SW];
            for (int b = 0; b < w; b++)
              m_sq[s].push_back(b < SW ? int'(smp[SW-1-b]) : 0);
          end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_total = 0;
    end else if (bit_en) begin
      if ((m_pos >= m_total || m_pos == m_total - 1) && blk_ready) begin
        build_model();
        m_pos = 0;
      end else if (m_pos < m_total) begin
        m_pos++;
      end
    end
  end

  task automatic compare();
    logic       busy_e, sfs_e, pop_e;
    logic [3:0] so_e;
    int         idx;
    busy_e = (m_pos < m_total);
    sfs_e  = busy_e && (m_pos == 0);
    for (int p = 0; p < 4; p++) begin
      idx = int'(m_sel[2*p +: 2]);
      so_e[p] = (busy_e && m_pos < m_sq[idx].size()) ? 1'(m_sq[idx][m_pos]) : 1'b0;
    end
    pop_e = bit_en && blk_ready && (!busy_e || m_pos == m_total - 1);
    n_tests++;
    if ({sout, sfs, blk_pop} !== {so_e, sfs_e, pop_e}) begin
      n_fail++;
      $display("FAIL %s pos=%0d sout/sfs/pop got %b/%b/%b exp %b/%b/%b",
               tag, m_pos, sout, sfs, blk_pop, so_e, sfs_e, pop_e);
    end
  endtask

  task automatic step();
    bit_en    = (en_mode == 0) ? 1'b1 : ($urandom % 3 == 0);
    blk_ready = (rdy_mode == 0) ? 1'b1 : ($urandom % 4 == 0);
    di = {$urandom(), $urandom(), $urandom()};
    dq = {$urandom(), $urandom(), $urandom()};
    if (churn && ($urandom % 7 == 0)) begin
      wsel      = 3'($urandom % 6);
      real_only = 1'($urandom);
      pack      = 2'($urandom);
      flen      = 6'($urandom % 12);
      psel      = 8'($urandom);
    end
  endtask

  task automatic run(input string t, input int cycles);
    tag = t;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #1;
      compare();
      step();
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired in %s", tag);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state
    n_tests++;
    if ({sout, sfs, blk_pop} !== 6'b0) begin
      n_fail++;
      $display("FAIL R12 reset got %b exp 000000", {sout, sfs, blk_pop});
    end
    rst_n = 1'b1;
    run("R12", 4);
    // R1 R9 R10: one channel per pin, complex 24-bit, sparse bit enables
    en_mode = 1; rdy_mode = 0;
    run("R1 R9 R10", 800);
    // R2: real-only
    real_only = 1'b1;
    run("R2", 800);
    real_only = 1'b0;
    // R3 R4: every word length
    en_mode = 0;
    for (int c = 0; c < 6; c++) begin
      wsel = 3'(c);
      run("R3 R4", 400);
    end
    wsel = 3'd3;
    // R5: packing modes
    for (int c = 0; c < 4; c++) begin
      pack = 2'(c);
      run("R5", 600);
    end
    // R7: minimum frame length with idle fill
    pack = 2'd0; flen = 6'd20;
    run("R7", 2500);
    flen = 6'd63; wsel = 3'd5;
    run("R7", 5000);
    flen = 6'd0; wsel = 3'd1; pack = 2'd2;
    // R8: pin routing
    psel = 8'b00_01_10_11;
    run("R8", 600);
    pack = 2'd1; psel = 8'b01_01_00_00;
    run("R8", 600);
    // R6: irregular block availability, back-to-back starts
    rdy_mode = 1;
    run("R6", 1500);
    en_mode = 1;
    run("R6 R10", 1500);
    // R11: configuration changes while frames run
    churn = 1; en_mode = 0; rdy_mode = 0;
    run("R11", 3000);
    churn = 0;
    summary();
    $finish;
  end

endmodule